// File: doc/BRIEF.md
# Word Memory with Mapped Character Console

This block is the data memory of a small 16-bit processor. Storage is organised as whole words, one per address, and is reached through a single request port that either reads or writes. Out of the address space, the lowest `DEPTH` words are real storage. Any address from `DEPTH` upward is out of range: it raises a fault flag in the same cycle as the request and has no other effect.

One address inside the storage range, `CON_ADDR`, also acts as a character console. A write there stores the word and sends its low byte out on a one-cycle transmit strobe. A read there waits for a character from the receive handshake, holding a stall signal high until one arrives. The character, zero-extended, is written into that location and returned as the read data. Read data is registered and comes out one cycle after the request is accepted, together with a one-cycle valid pulse. A write updates storage on the clock edge that accepts it.

The full-size configuration uses `DEPTH = 57344` (0xE000) with `CON_ADDR = 32768` (0x8000). The defaults are smaller so that the storage stays small when the block is elaborated on its own.

Top module: `wordmem_console`

## Requirements
- R1: After reset, every storage location reads as zero, and `rd_valid` and `con_tx_valid` are low.
- R2: A read request to an in-range address other than `CON_ADDR` is accepted in the cycle it is presented. In the following cycle, `rd_data` holds the word most recently written there and `rd_valid` is high for exactly one cycle.
- R3: A write request to an in-range address updates that word on the accepting clock edge, so a read issued in the very next cycle returns the new value.
- R4: `fault` is high in the same cycle as any request whose address is at or above `DEPTH`. Such a request changes no storage word, including the word at the same low address bits. It produces no `rd_valid`, no `con_tx_valid` and no `con_rx_ready`.
- R5: Address `DEPTH-1` is in range and stores normally. Address `DEPTH` faults.
- R6: While a read of `CON_ADDR` is presented and `con_rx_valid` is low, `busy` and `con_rx_ready` are high and no `rd_valid` is produced.
- R7: When a read of `CON_ADDR` is presented and `con_rx_valid` is high, `busy` is low in that cycle. In the next cycle, `rd_data` equals `{8'h00, con_rx_data}` and `rd_valid` is high.
- R8: A write to `CON_ADDR` raises `con_tx_valid` in the same cycle, with `con_tx_data` equal to the low 8 bits of `req_wdata`. Writes to any other address leave `con_tx_valid` low.
- R9: With `req_valid` low, `busy`, `fault`, `con_rx_ready` and `con_tx_valid` are low, and no `rd_valid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Request stalled waiting for a console character |
| fault | output | 1 | Address at or above DEPTH |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Read data valid pulse |
| con_rx_valid | input | 1 | Console character available |
| con_rx_data | input | 8 | Console character |
| con_rx_ready | output | 1 | Block waits to take a console character |
| con_tx_valid | output | 1 | Console output strobe |
| con_tx_data | output | 8 | Console output character |

## Verification
The bench builds the block with `DEPTH = 64` and `CON_ADDR = 32`, keeping `ADDR_W` and `DATA_W` at 16. The top in-range word (63) and the first faulting word (64) are then only a few addresses apart. Address 69 shares its low six bits with word 5, so an out-of-range write that leaked into storage would show up on a read of word 5. The small size also lets the bench read every word after reset in a few hundred cycles, and it places the console address in the middle of storage, so neighbouring words can be checked for untouched behaviour.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_FAULT,
        ACC_MEM_RD,
        ACC_MEM_WR,
        ACC_CON_RD,
        ACC_CON_WR
    } acc_kind_e;
endpackage

// File: rtl/mm_decode.sv
module mm_decode #(
    parameter int ADDR_W   = 16,
    parameter int DEPTH    = 1024,
    parameter int CON_ADDR = 512
) (
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    output mm_pkg::acc_kind_e      kind
);
    import mm_pkg::*;

    localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(DEPTH);
    localparam logic [ADDR_W-1:0] CON_A = ADDR_W'(CON_ADDR);

    always_comb begin
        if (!req_valid)             kind = ACC_IDLE;
        else if (req_addr >= TOP_A) kind = ACC_FAULT;
        else if (req_addr == CON_A) kind = req_write ? ACC_CON_WR : ACC_CON_RD;
        else                        kind = req_write ? ACC_MEM_WR : ACC_MEM_RD;
    end
endmodule

// File: rtl/mm_store.sv
module mm_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (32'(widx) < DEPTH)) begin
            mem_d[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = (32'(ridx) < DEPTH) ? mem_q[ridx] : '0;
endmodule

// File: rtl/mm_console.sv
module mm_console (
    input  mm_pkg::acc_kind_e kind,
    input  logic              rx_valid,
    input  logic [7:0]        wbyte,
    output logic              busy,
    output logic              rx_ready,
    output logic              rx_take,
    output logic              tx_valid,
    output logic [7:0]        tx_data
);
    import mm_pkg::*;

    always_comb begin
        rx_ready = (kind == ACC_CON_RD);
        busy     = rx_ready && !rx_valid;
        rx_take  = rx_ready && rx_valid;
        tx_valid = (kind == ACC_CON_WR);
        tx_data  = tx_valid ? wbyte : 8'h00;
    end
endmodule

// File: rtl/wordmem_console.sv
module wordmem_console #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 1024,
    parameter int CON_ADDR = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              fault,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              con_rx_valid,
    input  logic [7:0]        con_rx_data,
    output logic              con_rx_ready,
    output logic              con_tx_valid,
    output logic [7:0]        con_tx_data
);
    import mm_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } out_t;

    acc_kind_e         kind;
    logic              rx_take;
    logic              st_we;
    logic [DATA_W-1:0] st_wdata;
    logic [DATA_W-1:0] st_rdata;
    logic [IDX_W-1:0]  idx;
    out_t              out_d, out_q;

    assign idx = req_addr[IDX_W-1:0];

    mm_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CON_ADDR(CON_ADDR)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .kind      (kind)
    );

    mm_console u_console (
        .kind     (kind),
        .rx_valid (con_rx_valid),
        .wbyte    (req_wdata[7:0]),
        .busy     (busy),
        .rx_ready (con_rx_ready),
        .rx_take  (rx_take),
        .tx_valid (con_tx_valid),
        .tx_data  (con_tx_data)
    );

    mm_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .widx  (idx),
        .wdata (st_wdata),
        .ridx  (idx),
        .rdata (st_rdata)
    );

    always_comb begin
        fault    = (kind == ACC_FAULT);
        st_we    = (kind == ACC_MEM_WR) || (kind == ACC_CON_WR) || rx_take;
        st_wdata = rx_take ? DATA_W'(con_rx_data) : req_wdata;
        out_d    = out_q;
        out_d.rd_valid = 1'b0;
        if (kind == ACC_MEM_RD) begin
            out_d.rd_data  = st_rdata;
            out_d.rd_valid = 1'b1;
        end else if (rx_take) begin
            out_d.rd_data  = DATA_W'(con_rx_data);
            out_d.rd_valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data  = out_q.rd_data;
    assign rd_valid = out_q.rd_valid;

    // R4: a faulting request reaches neither console side
    a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!con_tx_valid && !con_rx_ready && !busy));
    // R4: a faulting request yields no read data
    a_r4_fault_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !rd_valid);
    // R6: stall only for a console read without a character
    a_r6_busy_source: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (req_valid && !req_write && !con_rx_valid && !fault));
    // R6: stalled request produces no read data
    a_r6_busy_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);
    // R7: a taken character comes back zero-extended next cycle
    a_r7_rx_return: assert property (@(posedge clk) disable iff (!rst_n)
        (con_rx_valid && con_rx_ready) |=>
            (rd_valid && rd_data == DATA_W'($past(con_rx_data))));
    // R8: transmit strobe only for a write request
    a_r8_tx_source: assert property (@(posedge clk) disable iff (!rst_n)
        con_tx_valid |-> (req_valid && req_write && !fault));
    // R9: idle produces no read pulse
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rd_valid);
endmodule

// File: tb/wordmem_console_bench.sv
module wordmem_console_bench;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int DEP = 64;
    localparam int CON = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, fault, rd_valid, con_rx_ready, con_tx_valid;
    logic [DW-1:0] rd_data;
    logic          con_rx_valid = 1'b0;
    logic [7:0]    con_rx_data = '0;
    logic [7:0]    con_tx_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wordmem_console #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP), .CON_ADDR(CON)) u_wordmem_console (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .fault(fault),
        .rd_data(rd_data), .rd_valid(rd_valid), .con_rx_valid(con_rx_valid),
        .con_rx_data(con_rx_data), .con_rx_ready(con_rx_ready),
        .con_tx_valid(con_tx_valid), .con_tx_data(con_tx_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0; req_write = 1'b0; con_rx_valid = 1'b0;
        @(negedge clk);
    endtask

    // write one word; checks same-cycle console strobe and fault
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic exp_tx, input logic exp_fault, input string req);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1;
        chk({req, " fault"}, fault, exp_fault);
        chk({req, " tx_valid"}, con_tx_valid, exp_tx);
        if (exp_tx) chk({req, " tx_data"}, con_tx_data, d[7:0]);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " no rd_valid after write"}, rd_valid, 1'b0);
    endtask

    // read one word; data checked the cycle after
    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                      input logic exp_fault, input string req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        chk({req, " fault"}, fault, exp_fault);
        chk({req, " busy"}, busy, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rd_valid"}, rd_valid, !exp_fault);
        if (!exp_fault) chk({req, " rd_data"}, rd_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid at reset", rd_valid, 1'b0);
        chk("R1 tx_valid at reset", con_tx_valid, 1'b0);
        for (int i = 0; i < DEP; i++) begin
            if (i != CON) rd(AW'(i), '0, 1'b0, "R1 zero after reset");
        end
    endtask

    task automatic t_basic();
        wr(16'd3, 16'hBEEF, 1'b0, 1'b0, "R3 write");
        rd(16'd3, 16'hBEEF, 1'b0, "R3 read back next cycle");
        wr(16'd4, 16'h1234, 1'b0, 1'b0, "R2 write");
        wr(16'd5, 16'h00A5, 1'b0, 1'b0, "R2 write");
        rd(16'd4, 16'h1234, 1'b0, "R2 read");
        rd(16'd5, 16'h00A5, 1'b0, "R2 read");
        wr(16'd4, 16'hFFFF, 1'b0, 1'b0, "R3 overwrite");
        rd(16'd4, 16'hFFFF, 1'b0, "R3 overwrite read");
    endtask

    task automatic t_fault();
        wr(16'd69, 16'hDEAD, 1'b0, 1'b1, "R4 oob write");
        rd(16'd5, 16'h00A5, 1'b0, "R4 alias word untouched");
        rd(16'd69, '0, 1'b1, "R4 oob read");
        wr(16'hFFFF, 16'h0041, 1'b0, 1'b1, "R4 top address write");
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'd100;
        #1;
        chk("R4 no rx_ready on fault", con_rx_ready, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 no rd_valid on fault", rd_valid, 1'b0);
    endtask

    task automatic t_bound();
        wr(16'(DEP-1), 16'h7E7E, 1'b0, 1'b0, "R5 top word write");
        rd(16'(DEP-1), 16'h7E7E, 1'b0, "R5 top word read");
        wr(16'(DEP), 16'h1111, 1'b0, 1'b1, "R5 first oob write");
        rd(16'd0, 16'h0000, 1'b0, "R5 word 0 untouched");
    endtask

    task automatic t_con_read(input logic [7:0] ch, input int wait_cycles);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'(CON); con_rx_valid = 1'b0;
        for (int i = 0; i < wait_cycles; i++) begin
            #1;
            chk("R6 busy while waiting", busy, 1'b1);
            chk("R6 rx_ready while waiting", con_rx_ready, 1'b1);
            @(negedge clk);
            chk("R6 no rd_valid while stalled", rd_valid, 1'b0);
        end
        con_rx_valid = 1'b1; con_rx_data = ch;
        #1;
        chk("R7 busy drops with char", busy, 1'b0);
        @(negedge clk);
        req_valid = 1'b0; con_rx_valid = 1'b0;
        chk("R7 rd_valid", rd_valid, 1'b1);
        chk("R7 rd_data char", rd_data, {8'h00, ch});
        @(negedge clk);
        chk("R7 rd_valid one cycle", rd_valid, 1'b0);
    endtask

    task automatic t_con_write();
        wr(16'(CON), 16'hAB48, 1'b1, 1'b0, "R8 console write");
        wr(16'(CON), 16'h0021, 1'b1, 1'b0, "R8 console write 2");
        wr(16'(CON+1), 16'h0055, 1'b0, 1'b0, "R8 neighbour no tx");
        rd(16'(CON+1), 16'h0055, 1'b0, "R8 neighbour stored");
    endtask

    task automatic t_idle();
        req_valid = 1'b0; req_addr = 16'(CON); req_write = 1'b1; con_rx_valid = 1'b1;
        #1;
        chk("R9 idle busy", busy, 1'b0);
        chk("R9 idle fault", fault, 1'b0);
        chk("R9 idle rx_ready", con_rx_ready, 1'b0);
        chk("R9 idle tx_valid", con_tx_valid, 1'b0);
        @(negedge clk);
        chk("R9 idle rd_valid", rd_valid, 1'b0);
        idle_cycle();
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_basic();
                t_fault();
                t_bound();
                t_con_read(8'h41, 3);
                t_con_read(8'hF0, 0);
                t_con_write();
                t_idle();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule